// File: doc/BRIEF.md
# Serial Voltage-Error Word Receiver

This block sits between a remote voltage converter and the voltage control loop. The converter sends a short serial word that gives the present output-voltage error. A separate start-of-conversion strobe marks where each word begins. The word is clocked at half the system clock, so the receiver takes one data bit on every second system clock edge. It then passes a sign-extended error sample to the loop, together with a one-cycle valid strobe.

The receiver keeps the last good sample on its output until a new word completes. A start-of-conversion that arrives while a word is still being assembled throws away the partial word and starts a new frame. It also raises a framing-error flag. The flag stays set until a word completes cleanly.

Top module: `verr_rx`

## Requirements
- R1: While reset is held (synchronous, active high) and in the first cycle after it, `sample_o` is zero and `valid_o` and `frame_err_o` are low.
- R2: When `soc_i` is high at clock edge t, a frame starts. `err_i` is taken at edges t+2, t+4, ..., t+12, and the first bit taken is the most significant bit of the word.
- R3: `valid_o` is high for exactly one cycle, the cycle after edge t+12. It is low while a frame is being assembled.
- R4: The word is two's complement. `sample_o` holds it sign-extended to OUT_W bits, so 6'h20 gives 12'hFE0 and 6'h1F gives 12'h01F.
- R5: Outside a frame, `err_i` has no effect. Between valid strobes, `sample_o` keeps the last delivered value.
- R6: A `soc_i` that arrives while a frame has taken fewer than six bits does three things. It sets `frame_err_o` in the following cycle, it discards the partial word, and it starts a fresh frame of six bits timed from that `soc_i`.
- R7: `frame_err_o` stays high until the next word completes. It drops in the same cycle in which `valid_o` rises.
- R8: A `soc_i` on the same edge that takes the sixth bit still delivers that word. It does not set `frame_err_o`, and it starts the next frame from that edge.
- R9: The `err_i` value on the odd edges of a frame (t+1, t+3, ...) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soc_i | input | 1 | Start-of-conversion strobe, marks a new word |
| err_i | input | 1 | Serial error data, MSB first, half-rate |
| sample_o | output | OUT_W | Sign-extended error sample (held) |
| valid_o | output | 1 | One-cycle strobe with each new sample |
| frame_err_o | output | 1 | Sticky flag: a frame was cut short |

## Verification
The hardest cases to reach from the ports are the exact-boundary ones.

- **Coinciding strobe (R8):** a start-of-conversion lands on the very edge that takes the sixth bit. The back-to-back task raises `soc_i` in the same cycle as the last data bit. It then sends the next word with no further strobe, counting half-rate phases from that shared edge.
- **Aborted frame (R6):** a strobe cuts a frame short after a few bits. The bench checks that the flag appears and that the aborted value never shows up.
- **Off-phase bits (R9):** every frame drives the inverse of each data bit in the off-phase cycles. A receiver that samples on the wrong edge therefore produces the complement of the expected word.

// File: rtl/verr_rx_pkg.sv
package verr_rx_pkg;

  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_SHIFT = 1'b1
  } frame_state_t;

endpackage

// File: rtl/verr_halfrate.sv
// Half-rate sampling strobe. Realigned by start-of-conversion so that the
// first strobe falls two edges after the strobe edge.
module verr_halfrate (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  output logic tick
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || realign) phase_q <= 1'b0;
    else                phase_q <= ~phase_q;
  end

  assign tick = phase_q;

  // R2: the strobe never lasts two cycles in a row
  assert_tick_alternates_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2: without a realign the strobe reappears one cycle after a gap
  assert_tick_returns_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !realign) |=> tick);

endmodule

// File: rtl/verr_framer.sv
// Frame controller and shift register: counts half-rate bits after a
// start-of-conversion and reports completion or an early abort.
module verr_framer
  import verr_rx_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soc,
  input  logic              tick,
  input  logic              ser,
  output logic [WORD_W-1:0] word,
  output logic              done,
  output logic              abort
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  frame_state_t       state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WORD_W-2:0]  shreg_q;
  logic               take;

  assign take  = (state_q == FR_SHIFT) && tick;
  assign done  = take && (cnt_q == LAST_IDX);
  assign abort = soc && (state_q == FR_SHIFT) && !done;
  assign word  = {shreg_q, ser};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (soc) begin
      state_q <= FR_SHIFT;
      cnt_q   <= '0;
    end else if (take) begin
      shreg_q <= word[WORD_W-2:0];
      if (done) begin
        state_q <= FR_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the bit count stays inside the word while shifting
  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_SHIFT) |-> (cnt_q <= LAST_IDX));

  // R6: a start strobe always opens a fresh frame at bit zero
  assert_soc_restarts_R6: assert property (@(posedge clk) disable iff (rst)
    soc |=> (state_q == FR_SHIFT) && (cnt_q == '0));

  // R5: no completion outside a frame
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_IDLE) |-> !done && !abort);

endmodule

// File: rtl/verr_sample_reg.sv
// Registered output stage: sign extension, valid strobe, sticky frame error.
module verr_sample_reg #(
  parameter int WORD_W = 6,
  parameter int OUT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              abort,
  input  logic [WORD_W-1:0] word,
  output logic [OUT_W-1:0]  sample,
  output logic              valid,
  output logic              ferr
);

  logic [OUT_W-1:0] ext;

  generate
    if (OUT_W > WORD_W) begin : g_extend
      assign ext = {{(OUT_W-WORD_W){word[WORD_W-1]}}, word};
    end else begin : g_same
      assign ext = word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sample <= '0;
      valid  <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      valid <= done;
      if (done) begin
        sample <= ext;
        ferr   <= 1'b0;
      end else if (abort) begin
        ferr   <= 1'b1;
      end
    end
  end

  // R3: the valid strobe lasts a single cycle
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R5: the sample is held whenever no word completes
  assert_sample_held_R5: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(sample));

  // R6: an early strobe raises the framing flag
  assert_abort_flags_R6: assert property (@(posedge clk) disable iff (rst)
    abort |=> ferr);

  // R7: a completed word clears the flag together with the strobe
  assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> valid && !ferr);

  // R4: upper bits of a delivered sample all copy the sign bit
  assert_sign_ext_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((sample[OUT_W-1:WORD_W-1] == '0) || (sample[OUT_W-1:WORD_W-1] == '1)));

endmodule

// File: rtl/verr_rx.sv
module verr_rx #(
  parameter int WORD_W = 6,
  parameter int OUT_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soc_i,
  input  logic             err_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o,
  output logic             frame_err_o
);

  localparam int CNT_W = $clog2(WORD_W);

  logic              tick;
  logic              done;
  logic              abort;
  logic [WORD_W-1:0] word;

  verr_halfrate u_tick (
    .clk     (clk),
    .rst     (rst),
    .realign (soc_i),
    .tick    (tick)
  );

  verr_framer #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_framer (
    .clk   (clk),
    .rst   (rst),
    .soc   (soc_i),
    .tick  (tick),
    .ser   (err_i),
    .word  (word),
    .done  (done),
    .abort (abort)
  );

  verr_sample_reg #(
    .WORD_W (WORD_W),
    .OUT_W  (OUT_W)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .abort  (abort),
    .word   (word),
    .sample (sample_o),
    .valid  (valid_o),
    .ferr   (frame_err_o)
  );

  // R8: a strobe on the completing edge delivers the word without an error
  assert_coincide_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (soc_i && done) |=> valid_o && !frame_err_o);

endmodule

// File: tb/sim_verr_rx.sv
`timescale 1ns/1ps
module sim_verr_rx;

  localparam int WORD_W = 6;
  localparam int OUT_W  = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             soc_i = 1'b0;
  logic             err_i = 1'b0;
  logic [OUT_W-1:0] sample_o;
  logic             valid_o;
  logic             frame_err_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  bit  ferr_model = 1'b0;
  logic [OUT_W-1:0] last_sample = '0;

  always #2 clk = ~clk;

  verr_rx #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u0 (
    .clk(clk), .rst(rst), .soc_i(soc_i), .err_i(err_i),
    .sample_o(sample_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] sext(input logic [WORD_W-1:0] w);
    return {{(OUT_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  // Sends one word. In off-phase cycles err_i carries the inverse bit (R9).
  // soc_last raises soc_i with the final bit; skip_soc continues such a chain.
  task automatic frame(input logic [WORD_W-1:0] w, input bit soc_last, input bit skip_soc);
    if (!skip_soc) begin
      @(negedge clk); soc_i = 1'b1; err_i = ~w[WORD_W-1];
    end
    for (int k = WORD_W-1; k >= 0; k--) begin
      if (!(skip_soc && k == WORD_W-1)) begin
        @(negedge clk);
        chk("R3 valid low inside frame", valid_o, 1'b0);
      end
      soc_i = 1'b0;
      err_i = ~w[k];
      if (k == WORD_W-1) chk("R6/R7 frame_err during frame", frame_err_o, ferr_model);
      @(negedge clk);
      chk("R3 valid low inside frame", valid_o, 1'b0);
      err_i = w[k];
      if (k == 0 && soc_last) soc_i = 1'b1;
    end
    @(negedge clk);
    chk("R3 valid strobe after sixth bit", valid_o, 1'b1);
    chk("R2/R4 sample value", sample_o, sext(w));
    chk("R7 frame_err cleared on completion", frame_err_o, 1'b0);
    ferr_model  = 1'b0;
    last_sample = sext(w);
    soc_i = 1'b0;
    err_i = ~err_i;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid_o, 1'b0);
    chk("R1 sample in reset", sample_o, '0);
    chk("R1 frame_err in reset", frame_err_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 1'b0);
    chk("R1 sample after reset", sample_o, '0);
  endtask

  task automatic test_words();
    frame(6'h15, 1'b0, 1'b0);  // +21, R2
    frame(6'h2A, 1'b0, 1'b0);  // -22, R4
    frame(6'h20, 1'b0, 1'b0);  // most negative, R4
    frame(6'h1F, 1'b0, 1'b0);  // most positive, R4
    frame(6'h3F, 1'b0, 1'b0);  // -1, R4
    frame(6'h00, 1'b0, 1'b0);  // zero, R9 off-phase bits all ones
  endtask

  task automatic test_idle_hold();
    frame(6'h0B, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      err_i = i[0];
      chk("R5 no strobe while idle", valid_o, 1'b0);
      chk("R5 sample held while idle", sample_o, last_sample);
    end
  endtask

  task automatic test_abort();
    logic [WORD_W-1:0] junk_w = 6'h2D;
    @(negedge clk); soc_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); soc_i = 1'b0; err_i = ~junk_w[WORD_W-1-i];
      chk("R6 no strobe for partial word", valid_o, 1'b0);
      @(negedge clk); err_i = junk_w[WORD_W-1-i];
    end
    chk("R6 flag still clear before abort", frame_err_o, 1'b0);
    ferr_model = 1'b1;
    frame(6'h13, 1'b0, 1'b0);
    chk("R6 partial word not delivered", sample_o, sext(6'h13));
    @(negedge clk);
    chk("R7 flag stays clear", frame_err_o, 1'b0);
  endtask

  task automatic test_back_to_back();
    frame(6'h25, 1'b1, 1'b0);
    frame(6'h1A, 1'b1, 1'b1);   // R8 chained, no error flagged
    frame(6'h31, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 single strobe at chain end", valid_o, 1'b0);
    chk("R8 no framing error", frame_err_o, 1'b0);
  endtask

  initial begin
    test_reset();
    test_words();
    test_idle_hold();
    test_abort();
    test_back_to_back();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule